// File: doc/BRIEF.md
# Microprogram Sequencer with Variable-Format Microwords

This block is the address-sequencing half of a microprogrammed control unit. It keeps a control address register, a small read-only control store, a control buffer register holding the microword at the current address, and a one-deep return register. On every clock edge it chooses the next control address from four sources and loads both the address and the microword stored there. The four sources are: the current address plus one, the target field of a branch word, a map of the instruction opcode, and the saved return address. Between edges, the buffered microword either drives the control outputs or steers the branch logic.

Each 16-bit microword has a format flag in bit 15. A control word (flag 0) sends its 14 low bits out as control signals. It then steps to the next address, or, if its dispatch bit is set, jumps to the routine for the current opcode. A branch word (flag 1) holds the control outputs low for its cycle. It tests one of eight conditions against the ALU flags or the status inputs, and it can jump, call a microsubroutine or return from one. Every branch therefore costs one cycle with no control action.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, `car` becomes 0, `ctrl` becomes 0 and the return register becomes 0. The buffered word is cleared to all zeros, which behaves as a plain sequential control word, so the first edge after reset moves `car` to 1.
- R2: Bit 15 of a microword selects its format: 0 for a control word, 1 for a branch word. While a control word is buffered, `ctrl` equals its bits 13:0 and `car` equals the address it was read from.
- R3: A control word with bit 14 clear moves `car` to `car`+1 at the next edge, wrapping from 255 to 0.
- R4: A control word with bit 14 set loads `car` with {2'b11, opcode, 2'b00}, so opcode k starts at 0xC0 + 4k.
- R5: While a branch word is buffered, `ctrl` is all zeros.
- R6: A branch word holds its condition in bits 14:12, a status select in bits 9:8 and its target in bits 7:0. Code 0 always branches. Code 1 tests `alu_flags[0]` (zero), code 2 tests `alu_flags[1]` (carry), code 3 tests `alu_flags[2]` (negative) and code 4 tests `alu_flags[3]` (overflow). A true condition loads the target.
- R7: Condition code 5 tests `status[sel]`, where sel is bits 9:8 of the word.
- R8: A branch with codes 0 to 5 whose condition is false moves `car` to `car`+1.
- R9: Code 6 is a call. It always loads the target and saves `car`+1 in the return register.
- R10: Code 7 is a return. It loads `car` from the return register and clears that register, so a return without a pending call goes to address 0.
- R11: The control store is as follows. Address 0x01 holds a dispatch control word with `ctrl` 0x2001. Address 0x72 holds a return. Each address 0xC0+4k with k<8 holds a branch with code k and target 0x40+8k. Each address 0xC0+4k with k≥8 holds a code-5 branch with select k[1:0] and target 0x80+k. Every other address holds a sequential control word whose `ctrl` is its own address, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode of the current machine instruction, used by dispatch words |
| alu_flags | input | 4 | {overflow, negative, carry, zero} from the datapath |
| status | input | 4 | Status bits tested by condition code 5 |
| ctrl | output | 14 | Control signals of the buffered microword |
| car | output | 8 | Current control address |

## Verification
The bound checker watches several rules on every cycle. It checks the next-address rule for each microword kind: a sequential step, the alignment of an opcode dispatch, an unconditional or flag-driven jump, a status-bit test, and fall-through on a false condition. It also checks that branch words keep the control outputs quiet, that a call records the address after it and that a return consumes the saved address. Only the bench's directed runs through the actual microprogram can show the remaining behaviour. These runs cover the full walk from reset through dispatch into each opcode routine, a call and return that resumes at the right place, and a second return that drops to address 0. They also cover the wrap from 255 to 0 and the exact control pattern seen at each address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UADDR_W = 8;
  localparam int UWORD_W = 16;
  localparam int OPC_W   = 4;
  localparam int FLAG_W  = 4;
  localparam int STAT_W  = 4;
  localparam int CTRL_W  = UWORD_W - 2;
  localparam int COND_W  = 3;
  localparam int SEL_W   = 2;

  localparam int FMT_BIT  = UWORD_W - 1;
  localparam int MAP_BIT  = UWORD_W - 2;
  localparam int COND_LSB = UWORD_W - 1 - COND_W;
  localparam int SEL_LSB  = UADDR_W;

  typedef enum logic [COND_W-1:0] {
    C_ALWAYS = 3'd0,
    C_ZERO   = 3'd1,
    C_CARRY  = 3'd2,
    C_NEG    = 3'd3,
    C_OVF    = 3'd4,
    C_STAT   = 3'd5,
    C_CALL   = 3'd6,
    C_RET    = 3'd7
  } cond_e;

  function automatic logic [UADDR_W-1:0] addr_incr(input logic [UADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [UADDR_W-1:0] opc_map(input logic [OPC_W-1:0] op);
    return {{(UADDR_W-OPC_W-2){1'b1}}, op, 2'b00};
  endfunction

  function automatic cond_e word_cond(input logic [UWORD_W-1:0] w);
    return cond_e'(w[COND_LSB +: COND_W]);
  endfunction

  function automatic logic [SEL_W-1:0] word_sel(input logic [UWORD_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic [UADDR_W-1:0] word_target(input logic [UWORD_W-1:0] w);
    return w[UADDR_W-1:0];
  endfunction

  // Microprogram contents, computed per address.
  function automatic logic [UWORD_W-1:0] ustore_word(input logic [UADDR_W-1:0] a);
    logic [OPC_W-1:0]   k;
    logic [UWORD_W-1:0] w;
    k = a[OPC_W+1:2];
    w = {2'b00, {(CTRL_W-UADDR_W){1'b0}}, a};
    if (a == 8'h01) begin
      w = {1'b0, 1'b1, 14'h2001};
    end else if (a == 8'h72) begin
      w = {1'b1, C_RET, 12'h000};
    end else if (a[7:6] == 2'b11 && a[1:0] == 2'b00) begin
      if (!k[3]) w = {1'b1, k[2:0], 4'h0, 8'h40 + {2'b00, k[2:0], 3'b000}};
      else       w = {1'b1, C_STAT, 2'b00, k[1:0], 8'h80 + {4'h0, k}};
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int ADDR_W = UADDR_W,
  parameter int WORD_W = UWORD_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rom [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign rom[i] = ustore_word(ADDR_W'(i));
    end
  endgenerate

  assign word = rom[addr];
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
#(
  parameter int FL_W = FLAG_W,
  parameter int ST_W = STAT_W
) (
  input  cond_e            cond,
  input  logic [SEL_W-1:0] sel,
  input  logic [FL_W-1:0]  flags,
  input  logic [ST_W-1:0]  status,
  output logic             taken
);
  always_comb begin
    unique case (cond)
      C_ALWAYS: taken = 1'b1;
      C_ZERO:   taken = flags[0];
      C_CARRY:  taken = flags[1];
      C_NEG:    taken = flags[2];
      C_OVF:    taken = flags[3];
      C_STAT:   taken = status[sel];
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = UADDR_W,
  parameter int WORD_W = UWORD_W,
  parameter int OP_W   = OPC_W
) (
  input  logic [WORD_W-1:0] cbr,
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] ret,
  input  logic [OP_W-1:0]   opcode,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] ret_d,
  output logic              do_call,
  output logic              do_ret,
  output logic              do_jump
);
  logic [ADDR_W-1:0] seq_addr;
  assign seq_addr = addr_incr(car);

  always_comb begin
    next_addr = seq_addr;
    ret_d     = ret;
    do_call   = 1'b0;
    do_ret    = 1'b0;
    do_jump   = 1'b0;
    if (!cbr[FMT_BIT]) begin
      if (cbr[MAP_BIT]) next_addr = opc_map(opcode);
    end else begin
      unique case (word_cond(cbr))
        C_CALL: begin
          next_addr = word_target(cbr);
          ret_d     = seq_addr;
          do_call   = 1'b1;
        end
        C_RET: begin
          next_addr = ret;
          ret_d     = '0;
          do_ret    = 1'b1;
        end
        default: begin
          if (taken) begin
            next_addr = word_target(cbr);
            do_jump   = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = UADDR_W,
  parameter int WORD_W = UWORD_W,
  parameter int OP_W   = OPC_W,
  parameter int FL_W   = FLAG_W,
  parameter int ST_W   = STAT_W,
  localparam int CW    = WORD_W - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [FL_W-1:0] alu_flags,
  input  logic [ST_W-1:0] status,
  output logic [CW-1:0]   ctrl,
  output logic [ADDR_W-1:0] car
);
  logic [ADDR_W-1:0] car_q, next_addr, ret_q, ret_d;
  logic [WORD_W-1:0] cbr_q, rom_word;
  logic              taken, do_call, do_ret, do_jump;

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
    .addr (next_addr),
    .word (rom_word)
  );

  useq_cond #(.FL_W(FL_W), .ST_W(ST_W)) cond_i (
    .cond   (word_cond(cbr_q)),
    .sel    (word_sel(cbr_q)),
    .flags  (alu_flags),
    .status (status),
    .taken  (taken)
  );

  useq_next #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OP_W(OP_W)) next_i (
    .cbr       (cbr_q),
    .car       (car_q),
    .ret       (ret_q),
    .opcode    (opcode),
    .taken     (taken),
    .next_addr (next_addr),
    .ret_d     (ret_d),
    .do_call   (do_call),
    .do_ret    (do_ret),
    .do_jump   (do_jump)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= '0;
      cbr_q <= '0;
      ret_q <= '0;
    end else begin
      car_q <= next_addr;
      cbr_q <= rom_word;
      ret_q <= ret_d;
    end
  end

  assign ctrl = cbr_q[FMT_BIT] ? '0 : cbr_q[CW-1:0];
  assign car  = car_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [CTRL_W-1:0]    ctrl,
  input logic [UADDR_W-1:0]   car,
  input logic [UWORD_W-1:0]   cbr,
  input logic [UADDR_W-1:0]   ret,
  input logic [FLAG_W-1:0]    flags,
  input logic [STAT_W-1:0]    status
);
  logic is_br;
  logic [COND_W-1:0] cc;
  assign is_br = cbr[FMT_BIT];
  assign cc    = cbr[COND_LSB +: COND_W];

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (car == '0 && ctrl == '0 && ret == '0));

  p_branch_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    is_br |-> ctrl == '0);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!is_br && !cbr[MAP_BIT]) |=> car == $past(car) + 8'd1);

  p_map_align_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_br && cbr[MAP_BIT]) |=> (car[1:0] == 2'b00 && car[7:6] == 2'b11));

  p_take_always_r6: assert property (@(posedge clk) disable iff (rst)
    (is_br && cc == 3'd0) |=> car == $past(cbr[7:0]));

  p_take_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (is_br && cc == 3'd1 && flags[0]) |=> car == $past(cbr[7:0]));

  p_stat_test_r7: assert property (@(posedge clk) disable iff (rst)
    (is_br && cc == 3'd5 && status[cbr[9:8]]) |=> car == $past(cbr[7:0]));

  p_fall_through_r8: assert property (@(posedge clk) disable iff (rst)
    (is_br && cc == 3'd2 && !flags[1]) |=> car == $past(car) + 8'd1);

  p_call_save_r9: assert property (@(posedge clk) disable iff (rst)
    (is_br && cc == 3'd6) |=> (car == $past(cbr[7:0]) && ret == $past(car) + 8'd1));

  p_return_load_r10: assert property (@(posedge clk) disable iff (rst)
    (is_br && cc == 3'd7) |=> (car == $past(ret) && ret == '0));
endmodule

bind useq_top useq_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .ctrl   (ctrl),
  .car    (car),
  .cbr    (cbr_q),
  .ret    (ret_q),
  .flags  (alu_flags),
  .status (status)
);

// File: tb/useq_top_tb_top.sv
`timescale 1ns/1ps
module useq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic [3:0]  alu_flags = '0;
  logic [3:0]  status = '0;
  logic [13:0] ctrl;
  logic [7:0]  car;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  useq_top dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_flags(alu_flags),
    .status(status), .ctrl(ctrl), .car(car)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Sequential word: ctrl shows its own address (R11, R2).
  task automatic chk_plain(input string req, input int a);
    chk({req, " car"}, car, a);
    chk({req, " ctrl R2"}, ctrl, a);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    chk("R1 car in reset", car, 0);
    chk("R1 ctrl in reset", ctrl, 0);
    rst = 1'b0;
  endtask

  // Reset, then fetch through 0x01 into the dispatch word of op.
  task automatic to_dispatch(input int op);
    do_reset();
    opcode = op[3:0];
    step();
    chk("R1 first step", car, 1);
    chk("R11 dispatch ctrl", ctrl, 'h2001);
    step();
    chk("R4 mapped address", car, 'hC0 + 4 * op);
    chk("R5 branch ctrl quiet", ctrl, 0);
  endtask

  task automatic t_branch(input string req, input int op, input int fl,
                          input int st, input int exp);
    alu_flags = fl[3:0];
    status    = st[3:0];
    to_dispatch(op);
    step();
    chk_plain(req, exp);
  endtask

  task automatic t_call_return();
    alu_flags = '0;
    status    = '0;
    to_dispatch(6);
    step(); chk_plain("R9 call target", 'h70);
    step(); chk_plain("R3 in subroutine", 'h71);
    step(); chk("R10 return word car", car, 'h72);
    chk("R5 return word ctrl", ctrl, 0);
    step(); chk_plain("R9 R10 resume after call", 'hD9);
    step(); chk_plain("R3 step", 'hDA);
    step(); chk_plain("R3 step", 'hDB);
    step(); chk("R10 second return word", car, 'hDC);
    step(); chk_plain("R10 consumed return goes to 0", 0);
    step(); chk("R3 after zero", car, 1);
  endtask

  task automatic t_wrap();
    status = '0;
    to_dispatch(15);
    step(); chk_plain("R8 status false", 'hFD);
    step(); chk_plain("R3", 'hFE);
    step(); chk_plain("R3", 'hFF);
    step(); chk_plain("R3 wrap to zero", 0);
  endtask

  task automatic t_opcode_ignored();
    alu_flags = 4'hF;
    to_dispatch(0);
    step(); chk_plain("R6 always", 'h40);
    opcode = 4'h9;
    alu_flags = 4'h0;
    step(); chk_plain("R3 opcode and flags ignored by sequential word", 'h41);
  endtask

  initial begin
    do_reset();
    t_branch("R6 always",        0, 'h0, 0, 'h40);
    t_branch("R6 zero taken",    1, 'h1, 0, 'h48);
    t_branch("R8 zero false",    1, 'hE, 0, 'hC5);
    t_branch("R6 carry taken",   2, 'h2, 0, 'h50);
    t_branch("R8 carry false",   2, 'hD, 0, 'hC9);
    t_branch("R6 neg taken",     3, 'h4, 0, 'h58);
    t_branch("R8 neg false",     3, 'hB, 0, 'hCD);
    t_branch("R6 ovf taken",     4, 'h8, 0, 'h60);
    t_branch("R8 ovf false",     4, 'h7, 0, 'hD1);
    t_branch("R7 status0 taken", 5, 'h0, 'h1, 'h68);
    t_branch("R7 status0 false", 5, 'hF, 'hE, 'hD5);
    t_branch("R7 sel1 taken",    9, 'h0, 'h2, 'h89);
    t_branch("R7 sel1 false",    9, 'h0, 'hD, 'hE5);
    t_branch("R7 sel3 taken",   15, 'h0, 'h8, 'h8F);
    t_branch("R10 return no call", 7, 'h0, 0, 0);
    t_call_return();
    t_wrap();
    t_opcode_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule